// File: doc/BRIEF.md
# Priority-Controlled Parallel Register

This block is a register of configurable width. Every bit shares one rising clock and one set of control lines. On each rising edge the whole word can do one of four things: clear to zero, preset to all ones, capture a new data word, or keep its present value. Clear and preset are synchronous and override the load enable. A build-time parameter decides whether clear or preset wins when both are requested in the same cycle. The register drives both its stored word and the bitwise complement of that word.

A second build-time parameter adds an asynchronous clear input. When this option is on, pulling that input low empties the register at once, with no clock edge needed, and keeps it empty for as long as the input stays low. When the option is off, the input is still present on the port list but the register ignores it. The block is meant to hold state in a datapath that needs a known start value and a cheap way to force patterns.

Top module: `prio_reg`

## Requirements
- R1: With `sclr`=1 and `spre`=0, the next rising edge makes `q` all zeros, whatever `ld` and `din` are.
- R2: With `spre`=1 and `sclr`=0, the next rising edge makes `q` all ones, whatever `ld` and `din` are.
- R3: With SET_WINS=1 and both `sclr` and `spre` at 1, the next rising edge makes `q` all ones.
- R4: With SET_WINS=0 and both `sclr` and `spre` at 1, the next rising edge makes `q` all zeros.
- R5: With `sclr`=0, `spre`=0 and `ld`=1, the next rising edge copies `din` into `q`.
- R6: With `sclr`=0, `spre`=0 and `ld`=0, `q` keeps its value across the edge, and `din` has no effect on it.
- R7: `q_n` is always the bitwise inverse of `q`.
- R8: With ASYNC_CLR=1, `arst_n`=0 forces `q` to zero at once, without a clock edge, and holds it at zero through any edges while it stays low.
- R9: With ASYNC_CLR=0, `arst_n` has no effect, and the synchronous controls keep working while it is low.
- R10: `q` changes only on a rising clock edge. Changing the inputs between edges leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all bits |
| arst_n | input | 1 | Active-low asynchronous clear, used only when ASYNC_CLR=1 |
| sclr | input | 1 | Synchronous clear request |
| spre | input | 1 | Synchronous preset (all ones) request |
| ld | input | 1 | Load enable: 1 captures `din`, 0 holds |
| din | input | WIDTH | Parallel data word |
| q | output | WIDTH | Stored word |
| q_n | output | WIDTH | Bitwise complement of the stored word |

## Verification
The bench builds two 4-bit instances side by side. One has SET_WINS=1 with ASYNC_CLR=1. The other has SET_WINS=0 with ASYNC_CLR=0. Both receive the same stimulus, so every combination of clear, preset and load is seen under both priority settings. At four bits, every starting word and every data word can be swept, which covers all 8 control combinations across all 256 pairs of prior value and input value. Keeping the asynchronous option different between the two copies puts the immediate clear and the ignored clear pin in the same test window. While `arst_n` is low, a load on the reset-dominant copy confirms that the pin has no effect there.

// File: rtl/prio_reg_pkg.sv
package prio_reg_pkg;

    // Whole-word action chosen for the coming edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_ZERO = 2'd2,
        ACT_ONES = 2'd3
    } prio_act_e;

endpackage

// File: rtl/prio_reg_arb.sv
module prio_reg_arb
    import prio_reg_pkg::*;
#(
    parameter bit SET_WINS = 1'b1
) (
    input  logic      sclr,
    input  logic      spre,
    input  logic      ld,
    output prio_act_e act
);

    generate
        if (SET_WINS) begin : g_set_dom
            always_comb begin
                if (spre)       act = ACT_ONES;
                else if (sclr)  act = ACT_ZERO;
                else if (ld)    act = ACT_LOAD;
                else            act = ACT_HOLD;
            end
        end else begin : g_clr_dom
            always_comb begin
                if (sclr)       act = ACT_ZERO;
                else if (spre)  act = ACT_ONES;
                else if (ld)    act = ACT_LOAD;
                else            act = ACT_HOLD;
            end
        end
    endgenerate

endmodule

// File: rtl/prio_reg_cell.sv
module prio_reg_cell
    import prio_reg_pkg::*;
(
    input  prio_act_e act,
    input  logic      d,
    input  logic      cur,
    output logic      nxt
);

    always_comb begin
        unique case (act)
            ACT_LOAD: nxt = d;
            ACT_ZERO: nxt = 1'b0;
            ACT_ONES: nxt = 1'b1;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/prio_reg.sv
module prio_reg
    import prio_reg_pkg::*;
#(
    parameter int unsigned WIDTH     = 8,
    parameter bit          SET_WINS  = 1'b1,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             sclr,
    input  logic             spre,
    input  logic             ld,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_n
);

    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        logic [MSB:0] word;
    } reg_state_t;

    reg_state_t   st_d, st_q;
    prio_act_e    act_w;
    logic [MSB:0] cell_nxt;

    prio_reg_arb #(.SET_WINS(SET_WINS)) arb_i (
        .sclr (sclr),
        .spre (spre),
        .ld   (ld),
        .act  (act_w)
    );

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            prio_reg_cell cell_i (
                .act (act_w),
                .d   (din[b]),
                .cur (st_q.word[b]),
                .nxt (cell_nxt[b])
            );
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.word = cell_nxt;
    end

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) st_q <= '0;
                else         st_q <= st_d;
            end
        end else begin : g_sync
            wire unused_arst = arst_n;
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    assign q   = st_q.word;
    assign q_n = ~st_q.word;

endmodule

// File: rtl/prio_reg_chk.sv
module prio_reg_chk #(
    parameter int unsigned WIDTH     = 8,
    parameter bit          SET_WINS  = 1'b1,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input logic             clk,
    input logic             arst_n,
    input logic             sclr,
    input logic             spre,
    input logic             ld,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic [WIDTH-1:0] q_n
);

    logic past_vld = 1'b0;
    always_ff @(posedge clk) past_vld <= 1'b1;

    logic arst_ok;
    assign arst_ok = !ASYNC_CLR || arst_n;

    // R1
    clr_only_chk: assert property (@(posedge clk) disable iff (!past_vld)
        (arst_ok && sclr && !spre) |=> (q == '0));

    // R2
    pre_only_chk: assert property (@(posedge clk) disable iff (!past_vld)
        (arst_ok && spre && !sclr) |=> (q == '1));

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!past_vld)
        (SET_WINS && arst_ok && sclr && spre) |=> (q == '1));

    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (!past_vld)
        (!SET_WINS && arst_ok && sclr && spre) |=> (q == '0));

    // R5
    load_chk: assert property (@(posedge clk) disable iff (!past_vld || !arst_ok)
        (!sclr && !spre && ld) |=> (q == $past(din)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!past_vld || !arst_ok)
        (!sclr && !spre && !ld) |=> $stable(q));

    // R8
    async_clr_chk: assert property (@(posedge clk) disable iff (!past_vld)
        (ASYNC_CLR && !arst_n) |-> (q == '0));

    logic unused_qn;
    assign unused_qn = ^q_n;

endmodule

bind prio_reg prio_reg_chk #(
    .WIDTH     (WIDTH),
    .SET_WINS  (SET_WINS),
    .ASYNC_CLR (ASYNC_CLR)
) chk_i (.*);

// File: tb/prio_reg_tb_top.sv
module prio_reg_tb_top;

    localparam int W = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         arst_n, sclr, spre, ld;
    logic [W-1:0] din;
    logic [W-1:0] q_sd, qn_sd, q_rd, qn_rd;

    prio_reg #(.WIDTH(W), .SET_WINS(1'b1), .ASYNC_CLR(1'b1)) dut_i (
        .clk(clk), .arst_n(arst_n), .sclr(sclr), .spre(spre), .ld(ld),
        .din(din), .q(q_sd), .q_n(qn_sd)
    );

    prio_reg #(.WIDTH(W), .SET_WINS(1'b0), .ASYNC_CLR(1'b0)) dut_rd_i (
        .clk(clk), .arst_n(arst_n), .sclr(sclr), .spre(spre), .ld(ld),
        .din(din), .q(q_rd), .q_n(qn_rd)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [W-1:0] m_sd, m_rd;

    function automatic logic [W-1:0] model(input logic [W-1:0] prev, input logic r,
                                           input logic s, input logic l,
                                           input logic [W-1:0] d, input bit setw);
        logic [W-1:0] rm, sm, dm;
        rm = {W{r}};
        sm = {W{s}};
        dm = l ? d : prev;
        return setw ? ((~rm & dm) | sm) : ((~rm & dm) | (~rm & sm));
    endfunction

    function automatic string tag(input logic r, input logic s, input logic l, input bit setw);
        if (r && s) return setw ? "R3" : "R4";
        if (r)      return "R1";
        if (s)      return "R2";
        if (l)      return "R5";
        return "R6";
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic s, input logic l, input logic [W-1:0] d);
        @(negedge clk);
        sclr = r; spre = s; ld = l; din = d;
        #1;
        // R10: no change before the edge
        check("R10", q_sd, m_sd);
        check("R10", q_rd, m_rd);
        m_sd = model(m_sd, r, s, l, d, 1'b1);
        m_rd = model(m_rd, r, s, l, d, 1'b0);
        @(posedge clk);
        #1;
        check(tag(r, s, l, 1'b1), q_sd, m_sd);
        check(tag(r, s, l, 1'b0), q_rd, m_rd);
        check("R7", qn_sd, ~m_sd);
        check("R7", qn_rd, ~m_rd);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        arst_n = 1'b0; sclr = 1'b0; spre = 1'b0; ld = 1'b0; din = '0;
        m_sd = '0;
        m_rd = '0;
        @(negedge clk);
        @(negedge clk);
        // R8: reset state of the asynchronous-clear copy
        check("R8", q_sd, '0);
        arst_n = 1'b1;
        sclr   = 1'b1;
        @(posedge clk);
        #1;
        check("R1", q_sd, '0);
        check("R1", q_rd, '0);

        // Sweep all control combinations under both priorities
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < 8; c++) begin
                for (int d = 0; d < 16; d++) begin
                    step(1'b0, 1'b0, 1'b1, W'(p));
                    step(c[2], c[1], c[0], W'(d));
                end
            end
        end

        // R8 / R9: asynchronous clear pin
        step(1'b0, 1'b0, 1'b1, 4'hA);
        @(negedge clk);
        sclr = 1'b0; spre = 1'b0; ld = 1'b0;
        #2;
        arst_n = 1'b0;
        #1;
        check("R8", q_sd, '0);
        check("R9", q_rd, m_rd);
        m_sd = '0;
        ld   = 1'b1;
        din  = 4'h5;
        @(posedge clk);
        #1;
        check("R8", q_sd, '0);
        check("R9", q_rd, 4'h5);
        check("R7", qn_sd, 4'hF);
        m_rd = 4'h5;
        @(negedge clk);
        arst_n = 1'b1;
        ld     = 1'b0;
        step(1'b0, 1'b0, 1'b1, 4'h9);
        step(1'b0, 1'b0, 1'b0, 4'h6);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule